// File: doc/BRIEF.md
# Block Transfer and Search Step Sequencer

This block carries out one step of a byte-block move or a byte-block search. A step is started with a mode word and a set of operands: source pointer, destination pointer, a 16-bit remaining count, an 8-bit search key and the incoming flag byte. In copy mode the block reads one byte at the source address and writes it to the destination address. In search mode it reads one byte at the source address and compares the key against it. In both modes the pointers that were used move one place up or one place down, and the count drops by one. The result is a new flag byte, along with a verdict on whether the surrounding processor has to issue the instruction again.

Memory is reached through one request/acknowledge port that carries one byte per transaction. The block does no instruction fetch and holds no program counter. In repeat mode it instead raises `repeat_req` for one cycle and gives the extra cycle charge on `penalty_cycles`. The caller uses these to rewind and re-issue the instruction. Between steps the updated pointers, count and flags stay visible on the outputs, so the caller can feed them back in.

The controller has four states. **IDLE** waits for `start`. The *launch* transition goes to **READ**. **READ** holds a read request until acknowledge. On acknowledge, the *copy-advance* transition goes to **WRITE**, and the *search-finish* transition goes to **DONE**. **WRITE** holds a write request until acknowledge, then takes the *write-finish* transition to **DONE**. **DONE** lasts one cycle and then takes the *retire* transition back to IDLE.

Top module: `blkmv_seq`

## Requirements
- R1: A copy step reads the byte at `src_in` and then writes that same byte to `dst_in`. Afterwards `src_out` and `dst_out` each equal their input plus 1 when `op_dec`=0, or minus 1 when `op_dec`=1, with wraparound modulo 2^16.
- R2: A search step (`op_cmp`=1) makes one read at `src_in` and makes no write. `src_out` steps by ±1 as in R1, and `dst_out` equals `dst_in`.
- R3: `cnt_out` equals `cnt_in` minus 1 modulo 2^16, so an entry count of 0 gives 0xFFFF. Flag bit 2 of `flags_out` is 1 exactly when `cnt_out` is nonzero.
- R4: A copy step sets `flags_out` to (`flags_in` AND 0xE9), with bit 2 taken from R3. Bits 7, 6, 5, 3 and 0 are passed through, and bits 4 and 1 are cleared.
- R5: A search step computes d = key − byte (8 bits) and stores nothing. In `flags_out`: bit 7 = d[7], bit 6 = (d==0), bit 4 = bit 4 of (key XOR byte XOR d), bit 1 = 1, bit 0 = `flags_in`[0], bit 2 from R3, and bits 5 and 3 = 0.
- R6: In repeat copy mode (`op_rpt`=1, `op_cmp`=0), `repeat_req` is 1 at step completion exactly when `cnt_out` is nonzero. With `op_rpt`=0 it is always 0.
- R7: In repeat search mode, `repeat_req` is 1 only when `cnt_out` is nonzero and d is nonzero. A match (d==0) ends the repetition.
- R8: `step_done` is high for exactly one cycle per step. `repeat_req` and `penalty_cycles` are meaningful only in that cycle. `penalty_cycles` is 5 when `repeat_req` is 1 and 0 at all other times.
- R9: Once raised, `mem_req` stays high until `mem_ack`, with `mem_addr`, `mem_we` and `mem_wdata` held steady. Reads have `mem_we`=0 and writes have `mem_we`=1.
- R10: `start` has no effect while a step is in progress (`busy`=1). The operands latched at launch decide the result.
- R11: After reset, `mem_req`, `step_done`, `repeat_req` and `busy` are 0 and `penalty_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one step (taken only in IDLE) |
| op_cmp | input | 1 | 1 = search step, 0 = copy step |
| op_dec | input | 1 | 1 = pointers step down, 0 = up |
| op_rpt | input | 1 | 1 = repeat mode |
| src_in | input | 16 | Source pointer |
| dst_in | input | 16 | Destination pointer |
| cnt_in | input | 16 | Remaining count |
| key_in | input | 8 | Search key |
| flags_in | input | 8 | Incoming flag byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| busy | output | 1 | A step is in progress |
| step_done | output | 1 | One-cycle completion pulse |
| repeat_req | output | 1 | Re-issue the instruction |
| penalty_cycles | output | 3 | Extra cycle charge for a restart (0 or 5) |
| src_out | output | 16 | Updated source pointer |
| dst_out | output | 16 | Updated destination pointer |
| cnt_out | output | 16 | Updated count |
| flags_out | output | 8 | Updated flag byte |

## Verification
The hardest cases to reach from the ports are the ones where two termination conditions meet. One is a repeat search whose count reaches zero on a mismatch. Another is a repeat search that matches while the count is still nonzero. A third is an entry count of zero that wraps, combined with stepping down from address 0. Each of these is set up by choosing the key, memory byte and count in the vector table so that exactly one condition holds. The memory responder stretches its acknowledge by a chosen number of cycles, which makes the request-hold rule observable. In one directed step, `start` is held high and the operands are changed while the step is in flight. That test then checks that only one read took place and that the outputs follow the operands from launch.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cmp;
        logic dec;
        logic rpt;
    } seq_mode_t;

    localparam logic [BYTE_W-1:0] COPY_KEEP = 8'hE9;
    localparam logic [BYTE_W-1:0] SRCH_KEEP = 8'h01;
endpackage

// File: rtl/blkmv_ptrstep.sv
module blkmv_ptrstep #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic         dec,
    output logic [W-1:0] ptr_nxt
);
    always_comb begin
        if (dec) ptr_nxt = ptr - W'(1);
        else     ptr_nxt = ptr + W'(1);
    end
endmodule

// File: rtl/blkmv_flagcalc.sv
module blkmv_flagcalc
    import blkmv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  seq_mode_t          mode,
    input  logic [BYTE_W-1:0]  key,
    input  logic [BYTE_W-1:0]  rd_byte,
    input  logic [BYTE_W-1:0]  flags_old,
    input  logic [CNT_W-1:0]   cnt_nxt,
    output logic [BYTE_W-1:0]  flags_nxt,
    output logic               rep_nxt
);
    logic [BYTE_W-1:0] diff;
    logic              cnt_nz;
    logic              half;
    logic              diff_nz;

    always_comb begin
        diff    = key - rd_byte;
        diff_nz = |diff;
        cnt_nz  = |cnt_nxt;
        half    = |((key ^ rd_byte ^ diff) & 8'h10);
        if (mode.cmp) begin
            flags_nxt    = flags_old & SRCH_KEEP;
            flags_nxt[7] = diff[BYTE_W-1];
            flags_nxt[6] = ~diff_nz;
            flags_nxt[4] = half;
            flags_nxt[2] = cnt_nz;
            flags_nxt[1] = 1'b1;
            rep_nxt      = mode.rpt && cnt_nz && diff_nz;
        end else begin
            flags_nxt    = flags_old & COPY_KEEP;
            flags_nxt[2] = cnt_nz;
            rep_nxt      = mode.rpt && cnt_nz;
        end
    end
endmodule

// File: rtl/blkmv_ctl.sv
module blkmv_ctl
    import blkmv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_cmp,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       accept,
    output logic       rd_take,
    output logic       finish,
    output logic       mem_req,
    output logic       mem_we
);
    seq_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        accept    = 1'b0;
        rd_take   = 1'b0;
        finish    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    state_nxt = ST_READ;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    rd_take = 1'b1;
                    if (is_cmp) begin
                        finish    = 1'b1;
                        state_nxt = ST_DONE;
                    end else begin
                        state_nxt = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    finish    = 1'b1;
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // R1
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> ($past(state) == ST_READ || $past(state) == ST_WRITE));
endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int PEN_CYC = 5,
    localparam int PEN_W  = $clog2(PEN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_cmp,
    input  logic              op_dec,
    input  logic              op_rpt,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [BYTE_W-1:0] key_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              step_done,
    output logic              repeat_req,
    output logic [PEN_W-1:0]  penalty_cycles,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [BYTE_W-1:0] flags_out
);
    seq_state_e        state;
    seq_mode_t         mode_q;
    logic              accept, rd_take, finish;
    logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] key_q, flags_q, byte_q, byte_v, flags_nxt;
    logic              rep_q, rep_nxt;

    blkmv_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_cmp  (mode_q.cmp),
        .mem_ack (mem_ack),
        .state   (state),
        .accept  (accept),
        .rd_take (rd_take),
        .finish  (finish),
        .mem_req (mem_req),
        .mem_we  (mem_we)
    );

    blkmv_ptrstep #(.W(ADDR_W)) u_src_step (.ptr(src_q), .dec(mode_q.dec), .ptr_nxt(src_nxt));
    blkmv_ptrstep #(.W(ADDR_W)) u_dst_step (.ptr(dst_q), .dec(mode_q.dec), .ptr_nxt(dst_nxt));

    assign byte_v = rd_take ? mem_rdata : byte_q;

    blkmv_flagcalc #(.CNT_W(CNT_W)) u_flags (
        .mode      (mode_q),
        .key       (key_q),
        .rd_byte   (byte_v),
        .flags_old (flags_q),
        .cnt_nxt   (cnt_q - CNT_W'(1)),
        .flags_nxt (flags_nxt),
        .rep_nxt   (rep_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            key_q   <= '0;
            flags_q <= '0;
            byte_q  <= '0;
            rep_q   <= 1'b0;
        end else begin
            if (accept) begin
                mode_q  <= '{cmp: op_cmp, dec: op_dec, rpt: op_rpt};
                src_q   <= src_in;
                dst_q   <= dst_in;
                cnt_q   <= cnt_in;
                key_q   <= key_in;
                flags_q <= flags_in;
                rep_q   <= 1'b0;
            end
            if (rd_take) byte_q <= mem_rdata;
            if (finish) begin
                src_q   <= src_nxt;
                dst_q   <= mode_q.cmp ? dst_q : dst_nxt;
                cnt_q   <= cnt_q - CNT_W'(1);
                flags_q <= flags_nxt;
                rep_q   <= rep_nxt;
            end
        end
    end

    always_comb begin
        mem_addr       = (state == ST_WRITE) ? dst_q : src_q;
        mem_wdata      = byte_q;
        busy           = (state != ST_IDLE);
        step_done      = (state == ST_DONE);
        repeat_req     = step_done && rep_q;
        penalty_cycles = repeat_req ? PEN_W'(PEN_CYC) : '0;
        src_out        = src_q;
        dst_out        = dst_q;
        cnt_out        = cnt_q;
        flags_out      = flags_q;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R2
    srch_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mode_q.cmp);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);
    // R8
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_done |-> (penalty_cycles == '0 && !repeat_req));
    // R6
    rpt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_req |-> (cnt_out != '0 && mode_q.rpt));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_done) |-> (cnt_out == $past(cnt_out) - CNT_W'(1)));
endmodule

// File: tb/blkmv_seq_bench.sv
module blkmv_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_cmp = 1'b0, op_dec = 1'b0, op_rpt = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [7:0]  key_in = '0, flags_in = '0;
    logic        mem_req, mem_we, busy, step_done, repeat_req;
    logic [15:0] mem_addr, src_out, dst_out, cnt_out;
    logic [7:0]  mem_wdata, flags_out;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [2:0]  penalty_cycles;

    always #2.5 clk = ~clk;

    blkmv_seq u_blkmv_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_cmp(op_cmp), .op_dec(op_dec), .op_rpt(op_rpt),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .key_in(key_in), .flags_in(flags_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .step_done(step_done), .repeat_req(repeat_req),
        .penalty_cycles(penalty_cycles),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out)
    );

    int total = 0, bad = 0;
    int lat = 0, wait_n = 0;
    int rd_n = 0, wr_n = 0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [7:0]  wr_data = '0, mem_byte = '0;

    // memory responder: ack after lat waiting cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_n  <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_n >= lat) begin
                    mem_ack <= 1'b1;
                    wait_n  <= 0;
                    if (mem_we) begin
                        wr_n    <= wr_n + 1;
                        wr_addr <= mem_addr;
                        wr_data <= mem_wdata;
                    end else begin
                        rd_n      <= rd_n + 1;
                        rd_addr   <= mem_addr;
                        mem_rdata <= mem_byte;
                    end
                end else begin
                    wait_n <= wait_n + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // stimulus {cmp,dec,rpt, src,dst,cnt, key,flags_in,mem_byte} ; expect {src,dst,cnt,flags,rep}
    localparam int NV = 8;
    localparam logic [131:0] VEC [NV] = '{
        {3'b000, 16'h1000, 16'h2000, 16'h0003, 8'h00, 8'hFF, 8'h5A, 16'h1001, 16'h2001, 16'h0002, 8'hED, 1'b0},
        {3'b011, 16'h1000, 16'h2000, 16'h0002, 8'h00, 8'h00, 8'h33, 16'h0FFF, 16'h1FFF, 16'h0001, 8'h04, 1'b1},
        {3'b001, 16'h1234, 16'h4321, 16'h0001, 8'h00, 8'h16, 8'h00, 16'h1235, 16'h4322, 16'h0000, 8'h00, 1'b0},
        {3'b010, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hC3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h04, 1'b0},
        {3'b101, 16'h4000, 16'h5000, 16'h0005, 8'h50, 8'hFF, 8'h30, 16'h4001, 16'h5000, 16'h0004, 8'h07, 1'b1},
        {3'b111, 16'h4000, 16'h5000, 16'h0003, 8'h42, 8'h00, 8'h42, 16'h3FFF, 16'h5000, 16'h0002, 8'h46, 1'b0},
        {3'b100, 16'hFFFF, 16'h0100, 16'h0002, 8'h10, 8'hFE, 8'h01, 16'h0000, 16'h0100, 16'h0001, 8'h16, 1'b0},
        {3'b101, 16'h0200, 16'h0300, 16'h0001, 8'h00, 8'h01, 8'h01, 16'h0201, 16'h0300, 16'h0000, 8'h93, 1'b0}
    };

    task automatic wait_done();
        int n = 0;
        while (step_done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) begin
            total++; bad++;
            $display("FAIL R8 step_done timeout actual=0 expected=1");
        end
    endtask

    initial begin : watchdog
        #500000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 mem_req", 32'(mem_req), 0);
        check("R11 step_done", 32'(step_done), 0);
        check("R11 busy", 32'(busy), 0);
        check("R11 penalty", 32'(penalty_cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [131:0] v;
            int rd0, wr0;
            v = VEC[i];
            {op_cmp, op_dec, op_rpt} = v[131:129];
            src_in = v[128:113]; dst_in = v[112:97]; cnt_in = v[96:81];
            key_in = v[80:73]; flags_in = v[72:65]; mem_byte = v[64:57];
            lat = i % 3;
            rd0 = rd_n; wr0 = wr_n;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            check("R1/R2 src_out", 32'(src_out), 32'(v[56:41]));
            check("R1/R2 dst_out", 32'(dst_out), 32'(v[40:25]));
            check("R3 cnt_out", 32'(cnt_out), 32'(v[24:9]));
            check(v[131] ? "R5 flags" : "R4 flags", 32'(flags_out), 32'(v[8:1]));
            check(v[131] ? "R7 repeat" : "R6 repeat", 32'(repeat_req), 32'(v[0]));
            check("R8 penalty", 32'(penalty_cycles), v[0] ? 32'd5 : 32'd0);
            check("R9 one read", 32'(rd_n - rd0), 1);
            check("R9 read addr", 32'(rd_addr), 32'(v[128:113]));
            if (v[131]) begin
                check("R2 no write", 32'(wr_n - wr0), 0);
            end else begin
                check("R1 one write", 32'(wr_n - wr0), 1);
                check("R1 write addr", 32'(wr_addr), 32'(v[112:97]));
                check("R1 write data", 32'(wr_data), 32'(v[64:57]));
            end
            @(negedge clk);
            check("R8 done pulse", 32'(step_done), 0);
            check("R8 penalty idle", 32'(penalty_cycles), 0);
        end

        // R10: start held and operands changed while busy
        begin
            int rd0;
            rd0 = rd_n;
            lat = 3;
            op_cmp = 1'b0; op_dec = 1'b0; op_rpt = 1'b1;
            src_in = 16'h0010; dst_in = 16'h0020; cnt_in = 16'h0008;
            flags_in = 8'h00; mem_byte = 8'h77;
            start = 1'b1;
            @(negedge clk);
            src_in = 16'h0999; cnt_in = 16'h0001; op_cmp = 1'b1;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            wait_done();
            check("R10 src_out", 32'(src_out), 32'h0011);
            check("R10 cnt_out", 32'(cnt_out), 32'h0007);
            check("R10 repeat", 32'(repeat_req), 1);
            check("R10 write data", 32'(wr_data), 32'h77);
            repeat (3) @(negedge clk);
            check("R10 single read", 32'(rd_n - rd0), 1);
            check("R10 idle", 32'(busy), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule